// File: doc/BRIEF.md
# MSI Event Queue Writer

This block takes incoming message-signalled interrupt writes, one at a time, and turns each one into a 64-byte record in a ring buffer in memory. A per-interrupt mapping table decides whether the interrupt is routed and to which queue it goes. A pending latch holds back a second record for the same interrupt until software has serviced the first one. Each queue is a ring of 128 slots, all inside one memory window that starts at a programmable base address. A record carries a nonzero type field, and that field is what tells the consumer the slot holds data.

Software drives a register port. Through it, it sets up the map, enables and disables queues, moves the head index as it consumes records, and clears pending latches. The block raises a per-queue not-empty flag whenever a queue holds unread records. If a record would fill the last free slot, the block drops that record and puts the queue into an error state with a sticky overflow flag.

The controller is a three-state machine:
- IDLE: accepts an interrupt through the TAKE transition.
- LOOKUP: checks the map and the queue, then leaves by one of three transitions.
  - ACCEPT goes to WRITE.
  - REJECT returns to IDLE with no effect.
  - DROP returns to IDLE and flags the overflow.
- WRITE: holds the memory write until it is accepted, then takes the DONE transition back to IDLE.

Top module: `msi_eq_writer`

## Requirements
- R1: After reset, every map entry reads as zero (invalid, not pending, queue 0), and every queue reads state 1 (idle) with head 0, tail 0 and overflow clear. In this state `msi_ready` is high, `mem_wr_valid` is low and `eq_not_empty` is zero.
- R2: An interrupt is accepted only when all of the following hold; otherwise it is discarded with no memory write and no register change:
  - its number (`msi_data`) is below the map size;
  - the upper five bits of `msi_fmt` are nonzero;
  - its map entry is valid;
  - its pending bit is clear;
  - its queue number addresses an existing queue, and that queue is active.
- R3: An accepted record is written at base + queue×8192 + tail×64. Word 0 is {0, fmt[6:0], len[9:0], addr[15:2], rid[15:0], data[15:0]} from bit 63 down to bit 0. Word 1 is {addr[63:16], 16'h0}. Address and words hold steady while `mem_wr_valid` waits for `mem_wr_ready`.
- R4: When the record write is accepted, the queue's tail advances by one and the interrupt's pending bit is set. Further interrupts with that number are discarded until software writes bit 62 to that number's pending-clear register.
- R5: The tail is a 7-bit index and wraps from 127 to 0.
- R6: If the advanced tail would equal the head, the record is dropped. The queue's overflow flag (tail register bit 57) is set and its state becomes 4 (error), where it accepts nothing.
- R7: Writing bit 44 to a queue's set register makes the queue active (state 2). Writing bit 44 to its clear register makes it idle (state 1). The state register always reads one-hot.
- R8: Bit 57 in the set register sets the overflow flag, and bit 57 in the clear register clears it. Neither write changes the queue state.
- R9: Software writes the head register. `eq_not_empty[q]` is high exactly when the head and tail of queue q differ.
- R10: In a map register, bit 63 is valid and bits 5:0 are the queue number; bit 62 reads the pending latch and is not writable there. A queue number at or beyond the queue count discards the interrupt.
- R11: `reg_addr[11:8]` selects the register kind and `reg_addr[7:0]` selects the queue or interrupt index. The kinds are:

  | Code | Register |
  |---|---|
  | 0 | base |
  | 1 | queue set |
  | 2 | queue clear |
  | 3 | state |
  | 4 | tail (write sets index) |
  | 5 | head |
  | 6 | map |
  | 7 | pending clear |

  The base register reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | Incoming interrupt write present |
| msi_ready | output | 1 | Block can take an interrupt (IDLE) |
| msi_fmt | input | 7 | Format/type code |
| msi_len | input | 10 | Length field |
| msi_rid | input | 16 | Requester ID |
| msi_addr | input | 62 | Write address, bits 63:2 |
| msi_data | input | 16 | Interrupt data, used as interrupt number |
| mem_wr_valid | output | 1 | Record write request |
| mem_wr_ready | input | 1 | Memory accepts the record |
| mem_wr_addr | output | 64 | Byte address of the record slot |
| mem_wr_word0 | output | 64 | First record word |
| mem_wr_word1 | output | 64 | Second record word |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register kind and index |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| eq_not_empty | output | 4 | Per-queue unread-records flag |

## Verification
The bench goes after the following corner cases:
- A repeated interrupt while its pending latch is set. A design that ignored the latch would write a duplicate record.
- A tail moving from slot 127 to 0. A wrong wrap would write outside the queue window or into the neighbour queue.
- A ring one slot short of full. A design with an off-by-one full test would overwrite unread records, or would stay silent without entering the error state.
- Held memory writes, to catch a record address that moves while it is stalled.
- Interrupts routed to idle queues, to invalid entries, and to queue numbers past the queue count, each of which must leave every register untouched.

// File: rtl/msi_eq_pkg.sv
package msi_eq_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LOOKUP = 2'd1,
        S_WRITE  = 2'd2
    } wr_state_e;

    typedef enum logic [2:0] {
        Q_IDLE   = 3'b001,
        Q_ACTIVE = 3'b010,
        Q_ERROR  = 3'b100
    } q_state_e;

    localparam logic [3:0] RG_BASE  = 4'd0;
    localparam logic [3:0] RG_SET   = 4'd1;
    localparam logic [3:0] RG_CLR   = 4'd2;
    localparam logic [3:0] RG_STATE = 4'd3;
    localparam logic [3:0] RG_TAIL  = 4'd4;
    localparam logic [3:0] RG_HEAD  = 4'd5;
    localparam logic [3:0] RG_MAP   = 4'd6;
    localparam logic [3:0] RG_PCLR  = 4'd7;

    localparam int EN_BIT    = 44;
    localparam int OVF_BIT   = 57;
    localparam int VLD_BIT   = 63;
    localparam int PND_BIT   = 62;
    localparam int REC_LG    = 6;

    function automatic logic [63:0] rec_word0(
        input logic [6:0]  fmt,
        input logic [9:0]  len,
        input logic [63:2] addr,
        input logic [15:0] rid,
        input logic [15:0] data
    );
        return {1'b0, fmt, len, addr[15:2], rid, data};
    endfunction

    function automatic logic [63:0] rec_word1(input logic [63:2] addr);
        return {addr[63:16], 16'h0000};
    endfunction

endpackage

// File: rtl/msi_map_table.sv
module msi_map_table
    import msi_eq_pkg::*;
#(
    parameter int NUM_MSI = 16,
    parameter int MSI_W   = $clog2(NUM_MSI),
    parameter int EQN_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             map_we_i,
    input  logic             map_valid_i,
    input  logic [EQN_W-1:0] map_eqn_i,
    input  logic             pend_clr_i,
    input  logic [MSI_W-1:0] cfg_idx_i,
    input  logic             pend_set_i,
    input  logic [MSI_W-1:0] pend_idx_i,
    input  logic [MSI_W-1:0] look_idx_i,
    output logic             look_valid_o,
    output logic             look_pend_o,
    output logic [EQN_W-1:0] look_eqn_o,
    output logic [63:0]      rd_word_o
);

    logic [NUM_MSI-1:0] vld_q;
    logic [NUM_MSI-1:0] pnd_q;
    logic [EQN_W-1:0]   eqn_q [NUM_MSI];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            pnd_q <= '0;
            for (int i = 0; i < NUM_MSI; i++) eqn_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_MSI; i++) begin
                if (map_we_i && cfg_idx_i == MSI_W'(i)) begin
                    vld_q[i] <= map_valid_i;
                    eqn_q[i] <= map_eqn_i;
                end
                if (pend_set_i && pend_idx_i == MSI_W'(i)) pnd_q[i] <= 1'b1;
                if (pend_clr_i && cfg_idx_i == MSI_W'(i))  pnd_q[i] <= 1'b0;
            end
        end
    end

    assign look_valid_o = vld_q[look_idx_i];
    assign look_pend_o  = pnd_q[look_idx_i];
    assign look_eqn_o   = eqn_q[look_idx_i];

    always_comb begin
        rd_word_o                 = '0;
        rd_word_o[VLD_BIT]        = vld_q[cfg_idx_i];
        rd_word_o[PND_BIT]        = pnd_q[cfg_idx_i];
        rd_word_o[EQN_W-1:0]      = eqn_q[cfg_idx_i];
    end

    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        pend_set_i && !(pend_clr_i && cfg_idx_i == pend_idx_i) |=> pnd_q[$past(pend_idx_i)]); // R4

endmodule

// File: rtl/eq_context.sv
module eq_context
    import msi_eq_pkg::*;
#(
    parameter int QIDX_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en_i,
    input  logic              set_ovf_i,
    input  logic              clr_en_i,
    input  logic              clr_ovf_i,
    input  logic              tail_we_i,
    input  logic              head_we_i,
    input  logic [QIDX_W-1:0] idx_wdata_i,
    input  logic              adv_i,
    input  logic              drop_i,
    output logic [QIDX_W-1:0] head_o,
    output logic [QIDX_W-1:0] tail_o,
    output q_state_e          state_o,
    output logic              ovf_o,
    output logic              not_empty_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_o  <= '0;
            tail_o  <= '0;
            state_o <= Q_IDLE;
            ovf_o   <= 1'b0;
        end else begin
            if (head_we_i) head_o <= idx_wdata_i;

            if (tail_we_i)  tail_o <= idx_wdata_i;
            else if (adv_i) tail_o <= tail_o + 1'b1;

            if (clr_en_i) state_o <= Q_IDLE;
            if (set_en_i) state_o <= Q_ACTIVE;
            if (drop_i)   state_o <= Q_ERROR;

            if (clr_ovf_i) ovf_o <= 1'b0;
            if (set_ovf_i) ovf_o <= 1'b1;
            if (drop_i)    ovf_o <= 1'b1;
        end
    end

    assign not_empty_o = (head_o != tail_o);

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_o) == 1); // R7
    AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && !tail_we_i |=> tail_o == QIDX_W'($past(tail_o) + 1'b1)); // R5
    AST_DROP_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        drop_i |=> state_o == Q_ERROR && ovf_o); // R6

endmodule

// File: rtl/eq_record_fmt.sv
module eq_record_fmt
    import msi_eq_pkg::*;
#(
    parameter int EQ_W   = 2,
    parameter int QIDX_W = 7
) (
    input  logic [63:0]       base_i,
    input  logic [EQ_W-1:0]   q_i,
    input  logic [QIDX_W-1:0] tail_i,
    input  logic [6:0]        fmt_i,
    input  logic [9:0]        len_i,
    input  logic [15:0]       rid_i,
    input  logic [63:2]       addr_i,
    input  logic [15:0]       data_i,
    output logic [63:0]       addr_o,
    output logic [63:0]       w0_o,
    output logic [63:0]       w1_o
);

    localparam int Q_SHIFT = QIDX_W + REC_LG;

    assign addr_o = base_i + (64'(q_i) << Q_SHIFT) + (64'(tail_i) << REC_LG);
    assign w0_o   = rec_word0(fmt_i, len_i, addr_i, rid_i, data_i);
    assign w1_o   = rec_word1(addr_i);

endmodule

// File: rtl/msi_eq_writer.sv
module msi_eq_writer
    import msi_eq_pkg::*;
#(
    parameter int NUM_MSI = 16,
    parameter int NUM_EQ  = 4,
    parameter int QIDX_W  = 7,
    parameter int EQN_W   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 msi_valid,
    output logic                 msi_ready,
    input  logic [6:0]           msi_fmt,
    input  logic [9:0]           msi_len,
    input  logic [15:0]          msi_rid,
    input  logic [63:2]          msi_addr,
    input  logic [15:0]          msi_data,
    output logic                 mem_wr_valid,
    input  logic                 mem_wr_ready,
    output logic [63:0]          mem_wr_addr,
    output logic [63:0]          mem_wr_word0,
    output logic [63:0]          mem_wr_word1,
    input  logic                 reg_we,
    input  logic [11:0]          reg_addr,
    input  logic [63:0]          reg_wdata,
    output logic [63:0]          reg_rdata,
    output logic [NUM_EQ-1:0]    eq_not_empty
);

    localparam int MSI_W = $clog2(NUM_MSI);
    localparam int EQ_W  = (NUM_EQ > 1) ? $clog2(NUM_EQ) : 1;
    localparam logic [EQN_W:0] EQ_LIM   = (EQN_W+1)'(NUM_EQ);
    localparam logic [7:0]     MSI_LIM8 = 8'(NUM_MSI);
    localparam logic [7:0]     EQ_LIM8  = 8'(NUM_EQ);

    wr_state_e fsm, nxt;

    logic [6:0]   cap_fmt;
    logic [9:0]   cap_len;
    logic [15:0]  cap_rid;
    logic [63:2]  cap_addr;
    logic [15:0]  cap_data;

    logic [63:0]      out_addr, out_w0, out_w1;
    logic [MSI_W-1:0] out_idx;
    logic [EQ_W-1:0]  out_q;
    logic [63:0]      base_q;

    logic             look_valid, look_pend;
    logic [EQN_W-1:0] look_eqn;
    logic [63:0]      map_rd;
    logic [EQ_W-1:0]  lk_q;

    logic [QIDX_W-1:0] q_head [NUM_EQ];
    logic [QIDX_W-1:0] q_tail [NUM_EQ];
    q_state_e          q_st   [NUM_EQ];
    logic [NUM_EQ-1:0] q_ovf;

    logic [NUM_EQ-1:0] adv_vec, drop_vec;
    logic              pend_set, take_write;
    logic              num_ok, type_ok, eq_ok, q_active, accept, full;
    logic [QIDX_W-1:0] lk_next_tail;
    logic [63:0]       rec_addr, rec_w0, rec_w1;

    logic [3:0] rg;
    logic [7:0] ridx;
    logic       q_sel_ok, m_sel_ok;
    logic [EQ_W-1:0] qsel;

    assign rg       = reg_addr[11:8];
    assign ridx     = reg_addr[7:0];
    assign q_sel_ok = ridx < EQ_LIM8;
    assign m_sel_ok = ridx < MSI_LIM8;
    assign qsel     = ridx[EQ_W-1:0];

    // lookup qualification
    assign lk_q         = look_eqn[EQ_W-1:0];
    assign num_ok       = (cap_data >> MSI_W) == '0;
    assign type_ok      = cap_fmt[6:2] != 5'd0;
    assign eq_ok        = {1'b0, look_eqn} < EQ_LIM;
    assign q_active     = q_st[lk_q] == Q_ACTIVE;
    assign accept       = num_ok && type_ok && look_valid && !look_pend && eq_ok && q_active;
    assign lk_next_tail = q_tail[lk_q] + 1'b1;
    assign full         = lk_next_tail == q_head[lk_q];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) fsm <= S_IDLE;
        else        fsm <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt        = fsm;
        msi_ready  = 1'b0;
        mem_wr_valid = 1'b0;
        pend_set   = 1'b0;
        take_write = 1'b0;
        adv_vec    = '0;
        drop_vec   = '0;
        unique case (fsm)
            S_IDLE: begin
                msi_ready = 1'b1;
                if (msi_valid) nxt = S_LOOKUP;            // TAKE
            end
            S_LOOKUP: begin
                if (accept && !full) begin                // ACCEPT
                    nxt        = S_WRITE;
                    take_write = 1'b1;
                end else begin
                    nxt = S_IDLE;                         // REJECT / DROP
                    if (accept) drop_vec[lk_q] = 1'b1;
                end
            end
            S_WRITE: begin
                mem_wr_valid = 1'b1;
                if (mem_wr_ready) begin                   // DONE
                    nxt            = S_IDLE;
                    pend_set       = 1'b1;
                    adv_vec[out_q] = 1'b1;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // capture and record registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_fmt  <= '0;
            cap_len  <= '0;
            cap_rid  <= '0;
            cap_addr <= '0;
            cap_data <= '0;
            out_addr <= '0;
            out_w0   <= '0;
            out_w1   <= '0;
            out_idx  <= '0;
            out_q    <= '0;
            base_q   <= '0;
        end else begin
            if (fsm == S_IDLE && msi_valid) begin
                cap_fmt  <= msi_fmt;
                cap_len  <= msi_len;
                cap_rid  <= msi_rid;
                cap_addr <= msi_addr;
                cap_data <= msi_data;
            end
            if (take_write) begin
                out_addr <= rec_addr;
                out_w0   <= rec_w0;
                out_w1   <= rec_w1;
                out_idx  <= cap_data[MSI_W-1:0];
                out_q    <= lk_q;
            end
            if (reg_we && rg == RG_BASE) base_q <= reg_wdata;
        end
    end

    assign mem_wr_addr  = out_addr;
    assign mem_wr_word0 = out_w0;
    assign mem_wr_word1 = out_w1;

    eq_record_fmt #(.EQ_W(EQ_W), .QIDX_W(QIDX_W)) u_fmt (
        .base_i (base_q),
        .q_i    (lk_q),
        .tail_i (q_tail[lk_q]),
        .fmt_i  (cap_fmt),
        .len_i  (cap_len),
        .rid_i  (cap_rid),
        .addr_i (cap_addr),
        .data_i (cap_data),
        .addr_o (rec_addr),
        .w0_o   (rec_w0),
        .w1_o   (rec_w1)
    );

    msi_map_table #(.NUM_MSI(NUM_MSI), .MSI_W(MSI_W), .EQN_W(EQN_W)) u_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .map_we_i     (reg_we && rg == RG_MAP && m_sel_ok),
        .map_valid_i  (reg_wdata[VLD_BIT]),
        .map_eqn_i    (reg_wdata[EQN_W-1:0]),
        .pend_clr_i   (reg_we && rg == RG_PCLR && m_sel_ok && reg_wdata[PND_BIT]),
        .cfg_idx_i    (ridx[MSI_W-1:0]),
        .pend_set_i   (pend_set),
        .pend_idx_i   (out_idx),
        .look_idx_i   (cap_data[MSI_W-1:0]),
        .look_valid_o (look_valid),
        .look_pend_o  (look_pend),
        .look_eqn_o   (look_eqn),
        .rd_word_o    (map_rd)
    );

    for (genvar g = 0; g < NUM_EQ; g++) begin : g_queue
        logic hit;
        assign hit = reg_we && ridx == 8'(g);
        eq_context #(.QIDX_W(QIDX_W)) u_ctx (
            .clk         (clk),
            .rst_n       (rst_n),
            .set_en_i    (hit && rg == RG_SET && reg_wdata[EN_BIT]),
            .set_ovf_i   (hit && rg == RG_SET && reg_wdata[OVF_BIT]),
            .clr_en_i    (hit && rg == RG_CLR && reg_wdata[EN_BIT]),
            .clr_ovf_i   (hit && rg == RG_CLR && reg_wdata[OVF_BIT]),
            .tail_we_i   (hit && rg == RG_TAIL),
            .head_we_i   (hit && rg == RG_HEAD),
            .idx_wdata_i (reg_wdata[QIDX_W-1:0]),
            .adv_i       (adv_vec[g]),
            .drop_i      (drop_vec[g]),
            .head_o      (q_head[g]),
            .tail_o      (q_tail[g]),
            .state_o     (q_st[g]),
            .ovf_o       (q_ovf[g]),
            .not_empty_o (eq_not_empty[g])
        );
    end

    // register read mux
    always_comb begin
        reg_rdata = '0;
        case (rg)
            RG_BASE:  reg_rdata = base_q;
            RG_STATE: if (q_sel_ok) reg_rdata[2:0] = q_st[qsel];
            RG_TAIL:  if (q_sel_ok) begin
                reg_rdata[QIDX_W-1:0] = q_tail[qsel];
                reg_rdata[OVF_BIT]    = q_ovf[qsel];
            end
            RG_HEAD:  if (q_sel_ok) reg_rdata[QIDX_W-1:0] = q_head[qsel];
            RG_MAP:   if (m_sel_ok) reg_rdata = map_rd;
            default:  reg_rdata = '0;
        endcase
    end

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr)
            && $stable(mem_wr_word0) && $stable(mem_wr_word1)); // R3
    AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> !msi_ready); // R3

endmodule

// File: tb/sim_msi_eq_writer.sv
`timescale 1ns/1ps
module sim_msi_eq_writer;

    localparam logic [3:0] K_BASE = 4'd0, K_SET = 4'd1, K_CLR = 4'd2, K_STATE = 4'd3,
                           K_TAIL = 4'd4, K_HEAD = 4'd5, K_MAP = 4'd6, K_PCLR = 4'd7;
    localparam logic [63:0] B_EN = 64'h1 << 44, B_OVF = 64'h1 << 57, B_PND = 64'h1 << 62;

    logic clk = 1'b0, rst_n = 1'b0;
    logic msi_valid = 1'b0, msi_ready;
    logic [6:0] msi_fmt = '0;
    logic [9:0] msi_len = '0;
    logic [15:0] msi_rid = '0, msi_data = '0;
    logic [63:2] msi_addr = '0;
    logic mem_wr_valid, mem_wr_ready = 1'b0;
    logic [63:0] mem_wr_addr, mem_wr_word0, mem_wr_word1;
    logic reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0, reg_rdata;
    logic [3:0] eq_not_empty;

    always #2.5 clk = ~clk;

    msi_eq_writer u0 (
        .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_ready(msi_ready),
        .msi_fmt(msi_fmt), .msi_len(msi_len), .msi_rid(msi_rid), .msi_addr(msi_addr),
        .msi_data(msi_data), .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_word0(mem_wr_word0), .mem_wr_word1(mem_wr_word1),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eq_not_empty(eq_not_empty)
    );

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    bit   m_vld [16];
    bit   m_pnd [16];
    int   m_eq  [16];
    int   q_st  [4];
    int   q_hd  [4];
    int   q_tl  [4];
    bit   q_ov  [4];
    logic [63:0] m_base = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_w0(input logic [6:0] f, input logic [9:0] l,
                                           input logic [63:2] a, input logic [15:0] r,
                                           input logic [15:0] d);
        logic [63:0] w = '0;
        w[62:56] = f; w[55:46] = l; w[45:32] = a[15:2]; w[31:16] = r; w[15:0] = d;
        return w;
    endfunction

    function automatic logic [63:0] exp_tailreg(input int q);
        return 64'(q_tl[q]) | (q_ov[q] ? B_OVF : 64'h0);
    endfunction

    task automatic reg_wr(input logic [3:0] k, input int idx, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = {k, 8'(idx)}; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_chk(input logic [3:0] k, input int idx, input logic [63:0] e, input string tag);
        @(negedge clk);
        reg_addr = {k, 8'(idx)};
        #1 chk(tag, reg_rdata, e);
    endtask

    task automatic set_map(input int n, input bit v, input int q);
        reg_wr(K_MAP, n, {v, 57'b0, 6'(q)});
        m_vld[n] = v; m_eq[n] = q;
    endtask
    task automatic clr_pend(input int n);
        reg_wr(K_PCLR, n, B_PND); m_pnd[n] = 1'b0;
    endtask
    task automatic set_head(input int q, input int h);
        reg_wr(K_HEAD, q, 64'(h)); q_hd[q] = h;
    endtask
    task automatic set_tail(input int q, input int t);
        reg_wr(K_TAIL, q, 64'(t)); q_tl[q] = t;
    endtask
    task automatic q_on(input int q);  reg_wr(K_SET, q, B_EN); q_st[q] = 2; endtask
    task automatic q_off(input int q); reg_wr(K_CLR, q, B_EN); q_st[q] = 1; endtask

    task automatic chk_ne(input string tag);
        logic [3:0] e;
        for (int q = 0; q < 4; q++) e[q] = (q_hd[q] != q_tl[q]);
        @(negedge clk);
        chk(tag, 64'(eq_not_empty), 64'(e));
    endtask

    // send one interrupt, predict the outcome, check it and update the model
    task automatic do_msi(input int num, input logic [6:0] fmt, input int stall, input string tag);
        logic [15:0] rid = 16'($urandom);
        logic [9:0]  len = 10'($urandom);
        logic [63:2] adr = {$urandom, 30'($urandom)};
        bit ok = 1'b0, full = 1'b0, got, stable = 1'b1;
        int q = -1;
        logic [63:0] ea, a0, w0, w1;
        if (num < 16 && fmt[6:2] != 0 && m_vld[num] && !m_pnd[num] && m_eq[num] < 4) begin
            q = m_eq[num];
            ok = (q_st[q] == 2);
            full = (((q_tl[q] + 1) % 128) == q_hd[q]);
        end else if (num < 16 && m_eq[num] < 4) q = m_eq[num];
        ea = m_base + 64'(q < 0 ? 0 : q) * 64'd8192 + 64'(q < 0 ? 0 : q_tl[q]) * 64'd64;
        @(negedge clk);
        msi_valid = 1'b1; msi_fmt = fmt; msi_len = len; msi_rid = rid; msi_addr = adr;
        msi_data = 16'(num);
        @(negedge clk);
        msi_valid = 1'b0;
        @(negedge clk);
        got = mem_wr_valid;
        chk({tag, " write issued"}, 64'(got), 64'(ok && !full));
        if (got) begin
            a0 = mem_wr_addr; w0 = mem_wr_word0; w1 = mem_wr_word1;
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                if (!mem_wr_valid || mem_wr_addr !== a0 || mem_wr_word0 !== w0) stable = 1'b0;
            end
            chk({tag, " held while stalled (R3)"}, 64'(stable), 64'd1);
            mem_wr_ready = 1'b1;
            @(negedge clk);
            mem_wr_ready = 1'b0;
            chk({tag, " slot address (R3)"}, a0, ea);
            chk({tag, " word0 (R3)"}, w0, exp_w0(fmt, len, adr, rid, 16'(num)));
            chk({tag, " word1 (R3)"}, w1, {adr[63:16], 16'h0});
        end else begin
            @(negedge clk);
        end
        if (ok && !full) begin
            q_tl[q] = (q_tl[q] + 1) % 128;
            m_pnd[num] = 1'b1;
        end else if (ok && full) begin
            q_ov[q] = 1'b1; q_st[q] = 4;
        end
        if (q >= 0) begin
            reg_chk(K_TAIL, q, exp_tailreg(q), {tag, " tail/overflow (R4 R6)"});
            reg_chk(K_STATE, q, 64'(q_st[q]), {tag, " state (R6 R7)"});
        end
        chk({tag, " ready again"}, 64'(msi_ready), 64'd1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [6:0] fmts [4];
        fmts[0] = 7'h58; fmts[1] = 7'h78; fmts[2] = 7'h30; fmts[3] = 7'h03;
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) begin m_vld[i] = 0; m_pnd[i] = 0; m_eq[i] = 0; end
        for (int q = 0; q < 4; q++) begin q_st[q] = 1; q_hd[q] = 0; q_tl[q] = 0; q_ov[q] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 msi_ready", 64'(msi_ready), 64'd1);
        chk("R1 mem_wr_valid", 64'(mem_wr_valid), 64'd0);
        chk("R1 not-empty", 64'(eq_not_empty), 64'd0);
        for (int q = 0; q < 4; q++) reg_chk(K_STATE, q, 64'd1, "R1 queue idle");
        reg_chk(K_TAIL, 2, 64'd0, "R1 tail zero");
        reg_chk(K_HEAD, 3, 64'd0, "R1 head zero");
        reg_chk(K_MAP, 5, 64'd0, "R1 map entry clear");

        // R11 base register
        m_base = 64'h0000_0040_0010_0000;
        reg_wr(K_BASE, 0, m_base);
        reg_chk(K_BASE, 0, m_base, "R11 base readback");

        // R7 enable
        q_on(0); q_on(1); q_on(2);
        reg_chk(K_STATE, 1, 64'd2, "R7 active");
        reg_chk(K_STATE, 3, 64'd1, "R7 untouched idle");

        for (int n = 0; n < 12; n++) set_map(n, 1'b1, n % 4);
        set_map(12, 1'b1, 5);
        set_map(13, 1'b0, 1);
        set_map(14, 1'b1, 0);
        set_map(15, 1'b1, 0);
        reg_chk(K_MAP, 12, {1'b1, 57'b0, 6'd5}, "R10 map readback");

        // R3 R4 basic record and pending latch
        do_msi(4, 7'h58, 0, "R3 first record");
        reg_chk(K_MAP, 4, {1'b1, 1'b1, 56'b0, 6'd0}, "R10 pending readback");
        chk_ne("R9 not-empty after write");
        do_msi(4, 7'h58, 0, "R4 pending blocks");
        reg_wr(K_MAP, 4, {1'b1, 1'b0, 56'b0, 6'd0});
        reg_chk(K_MAP, 4, {1'b1, 1'b1, 56'b0, 6'd0}, "R10 pending not writable via map");
        clr_pend(4);
        reg_chk(K_MAP, 4, {1'b1, 1'b0, 56'b0, 6'd0}, "R4 pending cleared");
        do_msi(4, 7'h78, 0, "R4 after clear");

        // R2 / R10 discards
        do_msi(13, 7'h58, 0, "R2 invalid entry");
        do_msi(3, 7'h58, 0, "R2 idle queue");
        do_msi(8, 7'h03, 0, "R2 zero type");
        do_msi(16, 7'h58, 0, "R2 number out of range");
        do_msi(12, 7'h58, 0, "R10 queue beyond count");
        chk_ne("R2 nothing changed");

        // R3 stall hold
        do_msi(0, 7'h78, 3, "R3 stalled write");

        // R9 head write empties queue
        set_head(0, q_tl[0]);
        reg_chk(K_HEAD, 0, 64'(q_tl[0]), "R9 head readback");
        chk_ne("R9 not-empty follows head");

        // R5 wrap
        set_tail(1, 126); set_head(1, 5);
        do_msi(1, 7'h58, 0, "R5 slot 126");
        do_msi(5, 7'h58, 0, "R5 slot 127");
        reg_chk(K_TAIL, 1, 64'd0, "R5 tail wrapped to 0");
        clr_pend(1); clr_pend(5);

        // R6 overflow
        set_head(2, (q_tl[2] + 1) % 128);
        do_msi(2, 7'h58, 0, "R6 full drop");
        reg_chk(K_TAIL, 2, exp_tailreg(2), "R6 overflow flag");
        do_msi(6, 7'h58, 0, "R6 error queue rejects");
        q_off(2);
        reg_chk(K_STATE, 2, 64'd1, "R7 disable to idle");
        q_on(2);
        reg_chk(K_STATE, 2, 64'd2, "R7 enable to active");
        reg_chk(K_TAIL, 2, exp_tailreg(2), "R8 overflow survives state change");
        reg_wr(K_CLR, 2, B_OVF); q_ov[2] = 0;
        reg_chk(K_TAIL, 2, exp_tailreg(2), "R8 overflow cleared");
        reg_chk(K_STATE, 2, 64'd2, "R8 state kept on clear");
        reg_wr(K_SET, 2, B_OVF); q_ov[2] = 1;
        reg_chk(K_TAIL, 2, exp_tailreg(2), "R8 overflow set");
        reg_chk(K_STATE, 2, 64'd2, "R8 state kept on set");
        reg_wr(K_CLR, 2, B_OVF); q_ov[2] = 0;
        set_head(2, q_tl[2]);

        // random traffic
        for (int it = 0; it < 300; it++) begin
            int r = $urandom_range(0, 99);
            if (r < 70) begin
                int n = ($urandom_range(0, 19) == 0) ? 16 : $urandom_range(0, 15);
                do_msi(n, fmts[$urandom_range(0, 3)], $urandom_range(0, 2), "R2 R4 random");
            end else if (r < 85) begin
                clr_pend($urandom_range(0, 15));
            end else if (r < 95) begin
                int q = $urandom_range(0, 3);
                set_head(q, (q_tl[q] + $urandom_range(0, 3)) % 128);
                chk_ne("R9 random head");
            end else begin
                int q = $urandom_range(0, 3);
                if ($urandom_range(0, 1) == 1) q_on(q); else q_off(q);
                reg_chk(K_STATE, q, 64'(q_st[q]), "R7 random state");
            end
        end

        done = 1'b1;
        finish_run();
    end

endmodule